// File: doc/BRIEF.md
# Byte-Addressed Two-Wire Register Slave

This block is a slave on a two-wire I2C bus. Through it an external master reads and writes a 256-location byte space that sits outside the block. The device answers to one 7-bit bus address. The six upper bits of that address are fixed at `101000`. The lowest bit follows the `dev_addr_lsb` pin, so two of these blocks can share one bus.

Each bus line passes through a small synchronizer. The block then finds START, STOP and clock edges on the system clock. It shifts bytes in and out, and it acknowledges a byte by asserting an open-drain enable that pulls SDA low.

An internal byte pointer picks the location. After the address byte of a write, the first byte loads the pointer. Every later data byte goes to the pointer, and the pointer then steps by one. A read sends the byte at the pointer, and the pointer steps past each byte sent. A read can start straight after a pointer write through a repeated START, or on its own from wherever the pointer was left. The storage port is synchronous and has a fixed latency with no back-pressure: a one-cycle write strobe, and a one-cycle read strobe whose data is taken on the next clock edge.

Top module: `i2cs_regfile_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `1010_00` followed by the level of `dev_addr_lsb`. For any other address, SDA stays released for that byte and for every later byte until the next START.
- R2: A START is SDA falling while SCL is high. It can come at any point, including in the middle of a transfer as a repeated START, and it always begins a new address phase.
- R3: An acknowledged byte makes `sda_oe` high for the whole ninth SCL pulse. The block releases `sda_oe` after that pulse ends. `sda_oe` never changes while SCL stays high, except when it is released on a START or a STOP.
- R4: In a write transfer, the first byte after the address byte loads the pointer, and the block acknowledges it.
- R5: Each later byte of a write produces one single-cycle `reg_wr_en` pulse with `reg_addr` set to the pointer and `reg_wdata` set to the byte. The pointer then steps by one.
- R6: A read transfer (R/W bit = 1) sends the byte at the pointer, MSB first, with `sda_oe` = NOT bit. This holds both after a repeated START that follows a pointer write and for a read with no pointer write before it.
- R7: While the master acknowledges, the block keeps sending consecutive locations. After a master NACK it releases SDA and sends nothing more. The pointer has then stepped past the last byte sent.
- R8: The pointer steps from 0xFF to 0x00, in both writes and reads.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle with `sda_oe` low. Bytes clocked after a STOP and without a new START are ignored: no acknowledge and no write.
- R10: `reg_rd_en` and `reg_wr_en` are never high in the same cycle. Each strobe lasts one cycle. Read data is taken from `reg_rdata` on the clock edge after the `reg_rd_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr_lsb | input | 1 | Level that sets bit 0 of the 7-bit device address |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| reg_wr_en | output | 1 | One-cycle write strobe to the byte store |
| reg_rd_en | output | 1 | One-cycle read strobe to the byte store |
| reg_addr | output | 8 | Location for the current strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr_en` |
| reg_rdata | input | 8 | Read data, valid on the edge after `reg_rd_en` |

## Verification
The checks on SDA stability assume that the master changes SDA only while SCL is low, except for START and STOP. They also assume that every SCL phase lasts well beyond the three-cycle delay of the synchronizer and edge detection. The bench drives each bit as four low cycles, eight high cycles and four low cycles. It moves SDA only in the low quarters and samples the line in the middle of the high phase. The store model in the bench always answers a read strobe on the next edge, as R10 demands.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;
  localparam logic [5:0] DEV_ADDR_HI = 6'b101000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } i2cs_state_e;

endpackage

// File: rtl/i2cs_sync_edge.sv
module i2cs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  // idle bus is high, so reset the chains to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_lsb,
  input  logic                scl_s,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  output logic                sda_oe,
  output logic                reg_wr_en,
  output logic                reg_rd_en,
  output logic [AW-1:0]       reg_addr,
  output logic [BYTE_W-1:0]   reg_wdata,
  input  logic [BYTE_W-1:0]   reg_rdata
);

  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] BITS_FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] BITS_LAST = CW'(BYTE_W - 1);

  i2cs_state_e         state, after_ack;
  logic [CW-1:0]       cnt;
  logic [BYTE_W-1:0]   sh, tx;
  logic [AW-1:0]       ptr;
  logic                rd_q, mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      ptr       <= '0;
      rd_q      <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      rd_q      <= reg_rd_en;
      if (rd_q) tx <= reg_rdata;

      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        mack   <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        mack   <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == BITS_FULL) begin
              cnt <= '0;
              case (state)
                ST_ADDR: begin
                  if (sh[BYTE_W-1:1] == {DEV_ADDR_HI, addr_lsb}) begin
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                    if (sh[0]) begin
                      after_ack <= ST_RDATA;
                      reg_rd_en <= 1'b1;
                      reg_addr  <= ptr;
                    end else begin
                      after_ack <= ST_PTR;
                    end
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_PTR: begin
                  ptr       <= sh[AW-1:0];
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  after_ack <= ST_WDATA;
                end
                default: begin
                  reg_wr_en <= 1'b1;
                  reg_addr  <= ptr;
                  reg_wdata <= sh;
                  ptr       <= ptr + 1'b1;
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  after_ack <= ST_WDATA;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state  <= after_ack;
              cnt    <= '0;
              sda_oe <= (after_ack == ST_RDATA) ? ~tx[BYTE_W-1] : 1'b0;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == BITS_LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
                ptr    <= ptr + 1'b1;
                cnt    <= '0;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                mack      <= 1'b1;
                reg_rd_en <= 1'b1;
                reg_addr  <= ptr;
              end else begin
                state <= ST_IDLE;
              end
            end else if (scl_fall && mack) begin
              mack   <= 1'b0;
              state  <= ST_RDATA;
              cnt    <= '0;
              sda_oe <= ~tx[BYTE_W-1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: the slave never moves SDA while SCL is high, apart from release on START/STOP
  a_r3_oe_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  // R3: SDA is only pulled in an acknowledge slot or while sending data
  a_r3_oe_only_ack_or_tx: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == ST_ACK || state == ST_RDATA));

  // R9: STOP leaves the block idle with SDA released
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe));

  // R5: write strobe lasts one cycle and the pointer has moved one past it
  a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  a_r5_ptr_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (ptr == reg_addr + 1'b1));

  // R10: strobes never overlap and read strobe lasts one cycle
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  a_r10_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);

endmodule

// File: rtl/i2cs_regfile_slave.sv
module i2cs_regfile_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_addr_lsb,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       reg_wr_en,
  output logic       reg_rd_en,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cs_sync_edge #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_ctrl #(.AW(8)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_lsb  (dev_addr_lsb),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: tb/test_i2cs_regfile_slave.sv
module test_i2cs_regfile_slave;

  localparam int CLK_PERIOD = 10;
  localparam int QTR = 4;
  localparam int HIGH = 8;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, reg_wr_en, reg_rd_en;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int n_tests = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int dbl_pulse = 0;
  logic prev_wr = 1'b0, prev_rd = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2cs_regfile_slave i_i2cs_regfile_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_addr_lsb (pin),
    .scl_i        (scl),
    .sda_i        (sda_line),
    .sda_oe       (sda_oe),
    .reg_wr_en    (reg_wr_en),
    .reg_rd_en    (reg_rd_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata)
  );

  // byte store model on the register port
  always @(posedge clk) begin
    if (reg_wr_en) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd_en) reg_rdata <= mem[reg_addr];
    if ((reg_wr_en && (prev_wr || reg_rd_en)) || (reg_rd_en && prev_rd))
      dbl_pulse <= dbl_pulse + 1;
    prev_wr <= reg_wr_en;
    prev_rd <= reg_rd_en;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(QTR);
    scl = 1'b1;   wclk(HIGH);
    sda_m = 1'b0; wclk(HIGH);
    scl = 1'b0;   wclk(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(QTR);
    scl = 1'b1;   wclk(HIGH);
    sda_m = 1'b1; wclk(HIGH);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(QTR);
      scl = 1'b1;   wclk(HIGH);
      scl = 1'b0;   wclk(QTR);
    end
    sda_m = 1'b1; wclk(QTR);
    scl = 1'b1;   wclk(HIGH/2);
    acked = (sda_line == 1'b0);
    wclk(HIGH/2);
    scl = 1'b0;   wclk(QTR);
  endtask

  task automatic recv_byte(input bit master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(QTR);
      scl = 1'b1; wclk(HIGH/2);
      b[i] = sda_line;
      wclk(HIGH/2);
      scl = 1'b0; wclk(QTR);
    end
    sda_m = master_ack ? 1'b0 : 1'b1; wclk(QTR);
    scl = 1'b1; wclk(HIGH);
    scl = 1'b0; wclk(QTR);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    int w0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    wclk(5);
    // reset state: released bus, no strobes (R9, R10)
    check(sda_oe == 1'b0 && reg_wr_en == 1'b0 && reg_rd_en == 1'b0, "R9 reset",
          {sda_oe, reg_wr_en, reg_rd_en}, 0);
    rst_n = 1'b1;
    wclk(5);

    // R1: sweep every 7-bit address with the pin low
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0}, ack);
      check(ack == (a == 'h50), "R1 address sweep", ack, (a == 'h50));
      bus_stop();
    end
    check(wr_cnt == 0, "R1 no writes in sweep", wr_cnt, 0);

    // R1: pin high moves the address, mismatched transfer ignored entirely
    pin = 1'b1;
    bus_start();
    send_byte(8'hA0, ack); check(!ack, "R1 pin high rejects 0x50", ack, 0);
    send_byte(8'h05, ack); check(!ack, "R1 later byte ignored", ack, 0);
    send_byte(8'h77, ack); check(!ack, "R1 later byte ignored", ack, 0);
    bus_stop();
    check(wr_cnt == 0, "R1 rejected transfer writes nothing", wr_cnt, 0);
    bus_start();
    send_byte(8'hA2, ack); check(ack, "R1 pin high accepts 0x51", ack, 1);
    send_byte(8'h50, ack); check(ack, "R4 pointer ack", ack, 1);
    send_byte(8'h99, ack); check(ack, "R5 data ack", ack, 1);
    bus_stop();
    exp_mem[8'h50] = 8'h99;
    check(mem[8'h50] == 8'h99, "R5 write at pointer", mem[8'h50], 8'h99);
    pin = 1'b0;

    // R5/R8: burst over all 256 locations from pointer 0
    w0 = wr_cnt;
    bus_start();
    send_byte(8'hA0, ack); check(ack, "R1 write address ack", ack, 1);
    send_byte(8'h00, ack); check(ack, "R4 pointer ack", ack, 1);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 5) & 255);
      exp_mem[i] = d;
      send_byte(d, ack);
      check(ack, "R3 data byte ack", ack, 1);
    end
    check(sda_oe == 1'b0, "R3 release after ack", sda_oe, 0);
    bus_stop();
    check(wr_cnt - w0 == 256, "R5 write count", wr_cnt - w0, 256);
    for (int i = 0; i < 256; i++)
      check(mem[i] == exp_mem[i], "R5 burst content", mem[i], exp_mem[i]);

    // R8: pointer wrap while writing
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'hFE, ack);
    send_byte(8'hA1, ack); send_byte(8'hB2, ack); send_byte(8'hC3, ack);
    bus_stop();
    exp_mem[8'hFE] = 8'hA1; exp_mem[8'hFF] = 8'hB2; exp_mem[8'h00] = 8'hC3;
    check(mem[8'hFF] == 8'hB2, "R8 write at 0xFF", mem[8'hFF], 8'hB2);
    check(mem[8'h00] == 8'hC3, "R8 write wraps to 0x00", mem[8'h00], 8'hC3);

    // R6/R7: pointer write then repeated START read of four bytes
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h10, ack);
    bus_start();
    send_byte(8'hA1, ack); check(ack, "R6 read address ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, rb);
      check(rb == exp_mem[8'h10 + i], "R6 repeated-start read", rb, exp_mem[8'h10 + i]);
    end
    check(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
    bus_stop();

    // R6/R7: read with no pointer write continues at 0x14
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, rb);
    check(rb == exp_mem[8'h14], "R7 pointer stepped past last read", rb, exp_mem[8'h14]);
    bus_stop();

    // R8: read all 257 bytes from 0, wrapping, then direct read lands at 1
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h00, ack);
    bus_stop();
    bus_start();
    send_byte(8'hA1, ack);
    for (int i = 0; i < 257; i++) begin
      recv_byte(i != 256, rb);
      check(rb == exp_mem[i & 255], "R8 read sweep with wrap", rb, exp_mem[i & 255]);
    end
    bus_stop();
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, rb);
    check(rb == exp_mem[1], "R8 pointer after read wrap", rb, exp_mem[1]);
    bus_stop();

    // R9: bytes after STOP without START are ignored
    w0 = wr_cnt;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h20, ack);
    bus_stop();
    send_byte(8'hA0, ack); check(!ack, "R9 no ack without START", ack, 0);
    send_byte(8'h55, ack); check(!ack, "R9 no ack without START", ack, 0);
    bus_stop();
    check(wr_cnt == w0, "R9 no write after STOP", wr_cnt, w0);
    check(mem[8'h20] == exp_mem[8'h20], "R9 location untouched", mem[8'h20], exp_mem[8'h20]);

    // R2: repeated START during a write restarts the address phase
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h30, ack);
    send_byte(8'h11, ack);
    bus_start();
    send_byte(8'hA0, ack); check(ack, "R2 address after repeated START", ack, 1);
    send_byte(8'h40, ack);
    send_byte(8'h22, ack);
    bus_stop();
    check(mem[8'h30] == 8'h11, "R2 first segment write", mem[8'h30], 8'h11);
    check(mem[8'h40] == 8'h22, "R2 second segment write", mem[8'h40], 8'h22);
    check(mem[8'h31] == exp_mem[8'h31], "R2 no spill past restart", mem[8'h31], exp_mem[8'h31]);

    // R10: strobes single-cycle and never overlapping over the whole run
    check(dbl_pulse == 0, "R10 strobe shape", dbl_pulse, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule